// File: doc/BRIEF.md
# Bidirectional Reloading Timer with Square-Wave Output

This block is a 16-bit timer with a companion 16-bit reload value. Each cycle in which the run control and the count-enable tick are both high, the count takes one step. Software can seed the count with any start value through a write port (equal to the reload value or not) and then raise the run control to begin. In the default up mode the count climbs to the all-ones value, reloads from the reload input and raises a sticky overflow flag.

When the bidirectional enable is high, an external direction pin chooses the way of counting. Counting down, the count reloads to all-ones once it has reached the reload value, and the overflow flag is set again. In this mode a side flag flips at every wrap in either direction, so it serves as a seventeenth count bit. It raises no interrupt.

A separate square-wave enable turns the timer into a programmable clock source. The count always climbs and reloads, and each wrap flips an output pin, which gives a 50% duty square wave whose period is twice the reload span. In this mode the overflow flag is left alone. Dropping the run control freezes the count, the flags and the output pin.

Top module: `updn_reload_timer`

## Requirements
- R1: After reset the count is 0x0000 and the overflow flag, the side flag and the square-wave output are all 0.
- R2: A count write loads the written value into the count at the next clock edge and takes priority over a count step in the same cycle; a write never causes a wrap.
- R3: With run and tick both 1, outside square-wave mode and not counting down, the count rises by one per step below 0xFFFF.
- R4: A rising step taken from 0xFFFF loads the reload value and sets the overflow flag.
- R5: With the bidirectional enable at 1 and the direction pin at 0 (1 = up, 0 = down), outside square-wave mode, a step falls by one unless the count equals the reload value; in that case it loads 0xFFFF and sets the overflow flag.
- R6: With the bidirectional enable at 0 the direction pin has no effect, and the count rises as in R3 and R4.
- R7: With the bidirectional enable at 1 and outside square-wave mode, the side flag inverts on every wrap, rising or falling; in every other cycle it holds.
- R8: With the square-wave enable at 1 the count always rises, a step from 0xFFFF loads the reload value and inverts the output pin, and the overflow flag is not set.
- R9: In a cycle where run or tick is 0 and no write or clear is given, the count, both flags and the output pin keep their values.
- R10: The overflow clear input resets the flag at the next edge; a wrap that sets the flag in the same cycle wins over the clear.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Count-enable tick |
| run_i | input | 1 | Run control |
| dir_up_i | input | 1 | Direction pin, 1 = up, 0 = down |
| updn_en_i | input | 1 | Bidirectional counting enable |
| sqw_en_i | input | 1 | Square-wave output mode enable |
| reload_i | input | 16 | Reload value |
| cnt_wr_i | input | 1 | Count write strobe |
| cnt_wdata_i | input | 16 | Count write data |
| ovf_clr_i | input | 1 | Overflow flag clear strobe |
| count_o | output | 16 | Current count |
| ovf_flag_o | output | 1 | Sticky overflow flag |
| side_flag_o | output | 1 | Seventeenth bit, inverts on each wrap |
| sqw_o | output | 1 | Square-wave output pin |

## Verification
The bench goes after the wrap points in both directions: a design that compares the falling count against zero instead of the reload value would underflow to a wrong value, and one that reloads one step late would show 0x0000 for a cycle. It drives the direction pin low with the bidirectional enable off, where a design that listened to the pin would count down. Square-wave runs check that the flag stays clear and that the pin inverts exactly once per reload span. The bench also hits a write and a wrap in the same cycle, and a clear and a set in the same cycle, where the wrong priority would drop an event.

// File: rtl/updn_tmr_pkg.sv
package updn_tmr_pkg;

  typedef enum logic [1:0] {
    MODE_RISE  = 2'd0,
    MODE_FALL  = 2'd1,
    MODE_SQW   = 2'd2
  } step_mode_t;

  // Square-wave mode overrides direction; the pin matters only when enabled.
  function automatic step_mode_t pick_mode(input logic sqw_en,
                                           input logic updn_en,
                                           input logic dir_up);
    if (sqw_en)                return MODE_SQW;
    else if (updn_en && !dir_up) return MODE_FALL;
    else                       return MODE_RISE;
  endfunction

endpackage

// File: rtl/updn_tmr_core.sv
module updn_tmr_core
  import updn_tmr_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         adv_i,
  input  logic         wr_i,
  input  logic [W-1:0] wdata_i,
  input  logic [W-1:0] reload_i,
  input  step_mode_t   mode_i,
  output logic [W-1:0] cnt_o,
  output logic         wrap_o
);

  localparam logic [W-1:0] TOP = '1;

  function automatic logic hits_edge(input logic [W-1:0] c,
                                     input logic [W-1:0] rl,
                                     input step_mode_t m);
    if (m == MODE_FALL) return (c == rl);
    else                return (c == TOP);
  endfunction

  function automatic logic [W-1:0] next_val(input logic [W-1:0] c,
                                            input logic [W-1:0] rl,
                                            input step_mode_t m);
    if (m == MODE_FALL) return (c == rl)  ? TOP : c - 1'b1;
    else                return (c == TOP) ? rl  : c + 1'b1;
  endfunction

  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_nxt;
  logic         at_edge;

  always_comb begin
    at_edge = hits_edge(cnt_q, reload_i, mode_i);
    cnt_nxt = next_val(cnt_q, reload_i, mode_i);
  end

  assign wrap_o = adv_i && !wr_i && at_edge;
  assign cnt_o  = cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt_q <= '0;
    else if (wr_i)  cnt_q <= wdata_i;
    else if (adv_i) cnt_q <= cnt_nxt;
  end

  assert_write_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_i |=> cnt_o == $past(wdata_i));

  assert_rise_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (adv_i && !wr_i && mode_i != MODE_FALL && cnt_o != TOP)
      |=> cnt_o == $past(cnt_o) + 1'b1);

  assert_rise_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (adv_i && !wr_i && mode_i != MODE_FALL && cnt_o == TOP)
      |=> cnt_o == $past(reload_i));

  assert_fall_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (adv_i && !wr_i && mode_i == MODE_FALL && cnt_o == reload_i)
      |=> cnt_o == TOP);

  assert_hold_count_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!adv_i && !wr_i) |=> $stable(cnt_o));

endmodule

// File: rtl/updn_tmr_flags.sv
module updn_tmr_flags
  import updn_tmr_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wrap_i,
  input  step_mode_t mode_i,
  input  logic       updn_en_i,
  input  logic       clr_i,
  output logic       ovf_o,
  output logic       side_o
);

  logic ovf_set;
  logic side_flip;
  logic ovf_q;
  logic side_q;

  assign ovf_set   = wrap_i && (mode_i != MODE_SQW);
  assign side_flip = ovf_set && updn_en_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovf_q  <= 1'b0;
      side_q <= 1'b0;
    end else begin
      if (ovf_set)    ovf_q <= 1'b1;
      else if (clr_i) ovf_q <= 1'b0;
      if (side_flip)  side_q <= ~side_q;
    end
  end

  assign ovf_o  = ovf_q;
  assign side_o = side_q;

  assert_side_flip_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap_i && updn_en_i && mode_i != MODE_SQW) |=> side_o != $past(side_o));

  assert_side_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !wrap_i |=> $stable(side_o));

  assert_no_flag_in_sqw_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap_i && mode_i == MODE_SQW && !clr_i) |=> $stable(ovf_o));

  assert_flag_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap_i && mode_i != MODE_SQW) |=> ovf_o);

  assert_flag_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !wrap_i) |=> !ovf_o);

endmodule

// File: rtl/updn_tmr_sqw.sv
module updn_tmr_sqw
  import updn_tmr_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wrap_i,
  input  step_mode_t mode_i,
  output logic       sqw_o
);

  logic flip;
  logic pin_q;

  assign flip = wrap_i && (mode_i == MODE_SQW);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    pin_q <= 1'b0;
    else if (flip) pin_q <= ~pin_q;
  end

  assign sqw_o = pin_q;

  assert_pin_flip_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap_i && mode_i == MODE_SQW) |=> sqw_o != $past(sqw_o));

  assert_pin_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !wrap_i |=> $stable(sqw_o));

endmodule

// File: rtl/updn_reload_timer.sv
module updn_reload_timer
  import updn_tmr_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick_i,
  input  logic         run_i,
  input  logic         dir_up_i,
  input  logic         updn_en_i,
  input  logic         sqw_en_i,
  input  logic [W-1:0] reload_i,
  input  logic         cnt_wr_i,
  input  logic [W-1:0] cnt_wdata_i,
  input  logic         ovf_clr_i,
  output logic [W-1:0] count_o,
  output logic         ovf_flag_o,
  output logic         side_flag_o,
  output logic         sqw_o
);

  step_mode_t mode;
  logic       adv;
  logic       wrap_evt;

  assign mode = pick_mode(sqw_en_i, updn_en_i, dir_up_i);
  assign adv  = run_i && tick_i;

  updn_tmr_core #(.W(W)) u_core (
    .clk     (clk),
    .rst_n   (rst_n),
    .adv_i   (adv),
    .wr_i    (cnt_wr_i),
    .wdata_i (cnt_wdata_i),
    .reload_i(reload_i),
    .mode_i  (mode),
    .cnt_o   (count_o),
    .wrap_o  (wrap_evt)
  );

  updn_tmr_flags u_flags (
    .clk      (clk),
    .rst_n    (rst_n),
    .wrap_i   (wrap_evt),
    .mode_i   (mode),
    .updn_en_i(updn_en_i),
    .clr_i    (ovf_clr_i),
    .ovf_o    (ovf_flag_o),
    .side_o   (side_flag_o)
  );

  updn_tmr_sqw u_sqw (
    .clk   (clk),
    .rst_n (rst_n),
    .wrap_i(wrap_evt),
    .mode_i(mode),
    .sqw_o (sqw_o)
  );

  assert_dir_ignored_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !cnt_wr_i && !updn_en_i && !sqw_en_i && count_o != '1)
      |=> count_o == $past(count_o) + 1'b1);

endmodule

// File: tb/updn_reload_timer_tb.sv
module updn_reload_timer_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_i = 1'b0, run_i = 1'b0, dir_up_i = 1'b1;
  logic        updn_en_i = 1'b0, sqw_en_i = 1'b0;
  logic [15:0] reload_i = 16'h0000;
  logic        cnt_wr_i = 1'b0;
  logic [15:0] cnt_wdata_i = 16'h0000;
  logic        ovf_clr_i = 1'b0;
  logic [15:0] count_o;
  logic        ovf_flag_o, side_flag_o, sqw_o;

  always #10 clk = ~clk;

  updn_reload_timer u_dut (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .run_i(run_i),
    .dir_up_i(dir_up_i), .updn_en_i(updn_en_i), .sqw_en_i(sqw_en_i),
    .reload_i(reload_i), .cnt_wr_i(cnt_wr_i), .cnt_wdata_i(cnt_wdata_i),
    .ovf_clr_i(ovf_clr_i), .count_o(count_o), .ovf_flag_o(ovf_flag_o),
    .side_flag_o(side_flag_o), .sqw_o(sqw_o)
  );

  int    checks = 0;
  int    errors = 0;
  string tag = "R1";
  bit    done = 0;

  // reference state
  int m_cnt = 0;
  bit m_ovf = 0, m_side = 0, m_pin = 0;

  task automatic chk(input string what, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s %s got %h expected %h", tag, what, got, exp);
    end
  endtask

  task automatic compare_all();
    chk("count", int'(count_o), m_cnt);
    chk("ovf",   int'(ovf_flag_o), int'(m_ovf));
    chk("side",  int'(side_flag_o), int'(m_side));
    chk("pin",   int'(sqw_o), int'(m_pin));
  endtask

  // advance the model by one edge using the inputs now on the pins
  task automatic model_edge();
    bit set = 0;
    if (cnt_wr_i) m_cnt = int'(cnt_wdata_i);
    else if (run_i && tick_i) begin
      if (sqw_en_i) begin
        if (m_cnt == 65535) begin m_cnt = int'(reload_i); m_pin = !m_pin; end
        else m_cnt = m_cnt + 1;
      end else if (updn_en_i && !dir_up_i) begin
        if (m_cnt == int'(reload_i)) begin m_cnt = 65535; set = 1; m_side = !m_side; end
        else m_cnt = (m_cnt + 65535) % 65536;
      end else begin
        if (m_cnt == 65535) begin
          m_cnt = int'(reload_i); set = 1;
          if (updn_en_i) m_side = !m_side;
        end else m_cnt = m_cnt + 1;
      end
    end
    if (set) m_ovf = 1;
    else if (ovf_clr_i) m_ovf = 0;
  endtask

  // inputs set at the falling edge, checked at the next falling edge
  task automatic cyc(input bit tk, input bit rn, input bit ud, input bit dr,
                     input bit sq, input bit wr, input logic [15:0] wd,
                     input bit clr);
    tick_i = tk; run_i = rn; updn_en_i = ud; dir_up_i = dr; sqw_en_i = sq;
    cnt_wr_i = wr; cnt_wdata_i = wd; ovf_clr_i = clr;
    model_edge();
    @(posedge clk);
    @(negedge clk);
    compare_all();
  endtask

  initial begin
    #3_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    tag = "R1";
    compare_all();
    rst_n = 1'b1;
    @(negedge clk);
    compare_all();

    // R2: write seeds the count
    tag = "R2"; reload_i = 16'h1234;
    cyc(1, 1, 0, 1, 0, 1, 16'hFFF0, 0);
    // R3 climb, R4 wrap to reload with flag
    tag = "R3";
    for (int i = 0; i < 14; i++) cyc(1, 1, 0, 1, 0, 0, 16'h0, 0);
    tag = "R4";
    for (int i = 0; i < 4; i++) cyc(1, 1, 0, 1, 0, 0, 16'h0, 0);
    // R10: clear, then clear during a wrap
    tag = "R10";
    cyc(0, 1, 0, 1, 0, 0, 16'h0, 1);
    cyc(1, 1, 0, 1, 0, 1, 16'hFFFF, 0);
    cyc(1, 1, 0, 1, 0, 0, 16'h0, 1);
    cyc(0, 0, 0, 1, 0, 0, 16'h0, 1);
    // R2: write beats a wrap in the same cycle
    tag = "R2";
    cyc(1, 1, 0, 1, 0, 1, 16'hFFFF, 0);
    cyc(1, 1, 0, 1, 0, 1, 16'h0042, 0);
    // R9: frozen with run low or tick low
    tag = "R9";
    for (int i = 0; i < 4; i++) cyc(1, 0, 1, 0, 0, 0, 16'h0, 0);
    for (int i = 0; i < 4; i++) cyc(0, 1, 1, 0, 1, 0, 16'h0, 0);
    // R5 fall to reload, then R7 side flag
    tag = "R5"; reload_i = 16'h0010;
    cyc(1, 1, 1, 0, 0, 1, 16'h0014, 0);
    for (int i = 0; i < 8; i++) cyc(1, 1, 1, 0, 0, 0, 16'h0, 0);
    tag = "R7";
    cyc(1, 1, 1, 1, 0, 1, 16'hFFFE, 0);
    for (int i = 0; i < 4; i++) cyc(1, 1, 1, 1, 0, 0, 16'h0, 0);
    // R6: pin low but bidirectional disabled
    tag = "R6";
    cyc(1, 1, 0, 0, 0, 1, 16'hFFFC, 1);
    for (int i = 0; i < 6; i++) cyc(1, 1, 0, 0, 0, 0, 16'h0, 0);
    // R8: square wave with a 4-step span
    tag = "R8"; reload_i = 16'hFFFC;
    cyc(0, 0, 0, 1, 1, 1, 16'hFFFC, 1);
    for (int i = 0; i < 24; i++) cyc(1, 1, 1, 0, 1, 0, 16'h0, 0);
    tag = "R9";
    for (int i = 0; i < 3; i++) cyc(1, 0, 0, 1, 1, 0, 16'h0, 0);

    // mixed random stimulus near the wrap points
    tag = "R7";
    for (int i = 0; i < 600; i++) begin
      if (($urandom % 50) == 0)
        reload_i = (($urandom % 2) == 0) ? 16'hFFF8 : 16'(16'hFFF0 + $urandom % 16);
      cyc(1'($urandom % 4 != 0), 1'($urandom % 8 != 0), 1'($urandom % 2),
          1'($urandom % 2), 1'($urandom % 6 == 0), 1'($urandom % 40 == 0),
          16'(16'hFFF0 + $urandom % 16), 1'($urandom % 10 == 0));
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule